// File: doc/BRIEF.md
# Gate-Driver Fault Guard

This block sits between two dead-time generators and the gate drivers of a full bridge. It takes four fault sources and decides, on every clock, whether the gate commands from the dead-time generators pass through or are replaced by a fixed safe pattern. The four sources are a supply-undervoltage comparator, an over-temperature comparator, an external active-low shutdown request and an internal watchdog on the PWM inputs. It also drives an active-low fault flag, meant to feed an open-drain pad. The comparators arrive as digital levels that already include their hysteresis. The shutdown request and the PWM inputs come straight from pins. All of these inputs pass through a synchronizer before any logic uses them.

The block is a three-state machine. CHARGE holds every high-side gate off and every low-side gate on, so that the bootstrap capacitors charge. It is the state after reset and the state forced by undervoltage. OFF holds every gate off and is forced by over-temperature, by the shutdown request or by PWM clock loss. RUN passes the dead-time generator outputs through and releases the fault flag.

The transitions are as follows:
- **uv_trip**: from any state to CHARGE, while undervoltage is present.
- **fault_trip**: from any state to OFF, while another fault is present and undervoltage is not.
- **resume**: from CHARGE or OFF to RUN, at a rising edge of any PWM input while no fault is present.
- **hold**: keeps the current state in every other case.

A fault does not wait for a PWM edge to take effect. Leaving a fault always waits for one.

Top module: `gate_fault_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released until the resume transition, gate_hs_o is all zeros, gate_ls_o is all ones and fault_n_o is 0.
- R2: In RUN, gate_hs_o equals dt_hs_i, gate_ls_o equals dt_ls_i and fault_n_o is 1, with no register between these inputs and the outputs.
- R3: A high uv_i sets gate_hs_o to all zeros, gate_ls_o to all ones and fault_n_o to 0. This takes effect at the third rising clock edge after the pin changes, whatever the PWM inputs do.
- R4: A high ot_i sets every gate output to 0 and fault_n_o to 0. This also takes effect at the third rising clock edge after the pin changes.
- R5: A low level on prot_n_i trips the OFF pattern if it lasts at least PROT_MIN_CYC clock cycles. A shorter low pulse has no effect on any output.
- R6: After a shutdown request is accepted, outputs stay forced until prot_n_i has returned high. Outputs then stay forced until a later PWM rising edge. A rising edge seen while prot_n_i is still low does not resume.
- R7: If no pwm_i bit changes for CLK_LOSS_CYC cycles, the OFF pattern is forced. Counting from the last pin change, outputs are still in RUN after CLK_LOSS_CYC+3 clock edges and forced after CLK_LOSS_CYC+4 edges.
- R8: Once a fault has cleared, outputs stay forced and fault_n_o stays 0 until a rising edge on either pwm_i bit. A falling edge, or a rising edge that comes while the fault is still present, does not resume.
- R9: When undervoltage and another fault are present together, the CHARGE pattern wins. fault_n_o stays 0 until every fault is gone and a resume has taken place.
- R10: Any pwm_i transition clears a clock-loss fault one cycle after it is seen. The rising edge that clears it does not itself resume; the next rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | NCH | Raw PWM inputs, one per bridge half (bit 0 side A, bit 1 side B) |
| uv_i | input | 1 | Undervoltage comparator result, 1 = supply too low |
| ot_i | input | 1 | Over-temperature comparator result, 1 = too hot |
| prot_n_i | input | 1 | External shutdown request, 0 = shut down |
| dt_hs_i | input | NCH | High-side commands from the dead-time generators |
| dt_ls_i | input | NCH | Low-side commands from the dead-time generators |
| gate_hs_o | output | NCH | High-side gate commands |
| gate_ls_o | output | NCH | Low-side gate commands |
| fault_n_o | output | 1 | Active-low fault flag, 0 = pull the open-drain line low |

## Verification
The embedded assertions check several rules on every cycle:
- a synchronized undervoltage always leads to the charge pattern, and any other fault always leads to all-off;
- the flag can rise only in a cycle that follows a detected PWM rising edge;
- a PWM transition always clears clock loss;
- a released shutdown request always drops the latched request.

Some behaviour can only be shown by the bench's scenarios. This covers the exact latencies, and the boundary between a shutdown pulse that is ignored and one that is accepted. It also covers the idle count at which clock loss trips, that the edge which clears a loss does not resume, and that a reset mid-operation returns to the charge pattern.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

    typedef enum logic [1:0] {
        ST_CHARGE = 2'd0,
        ST_OFF    = 2'd1,
        ST_RUN    = 2'd2
    } gfc_state_e;

    typedef struct packed {
        logic uv;
        logic ot;
        logic clk_lost;
        logic ext;
    } gfc_fault_t;

endpackage

// File: rtl/gfc_sync.sv
module gfc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gfc_edge_watch.sv
module gfc_edge_watch #(
    parameter int NPWM     = 2,
    parameter int LOSS_CYC = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPWM-1:0] pwm_s,
    output logic            rise_any,
    output logic            lost_o
);

    localparam int CW = $clog2(LOSS_CYC + 1);

    logic [NPWM-1:0] prev_q;
    logic [CW-1:0]   idle_q;
    logic            toggle;

    assign toggle   = |(pwm_s ^ prev_q);
    assign rise_any = |(pwm_s & ~prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            idle_q <= '0;
            lost_o <= 1'b0;
        end else begin
            prev_q <= pwm_s;
            if (toggle) begin
                idle_q <= '0;
                lost_o <= 1'b0;
            end else if (!lost_o) begin
                if (idle_q == CW'(LOSS_CYC - 1)) begin
                    lost_o <= 1'b1;
                end else begin
                    idle_q <= idle_q + 1'b1;
                end
            end
        end
    end

    // R10: any PWM transition removes the clock-loss fault on the next cycle
    a_r10_toggle_clears_loss: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> !lost_o);

    // R7: clock loss can only appear after a cycle without transitions
    a_r7_loss_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_o) |-> !$past(toggle));

endmodule

// File: rtl/gfc_ext_qual.sv
module gfc_ext_qual #(
    parameter int MIN_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_s,
    output logic ext_fault
);

    localparam int CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q     <= '0;
            ext_fault <= 1'b0;
        end else if (prot_s) begin
            low_q     <= '0;
            ext_fault <= 1'b0;
        end else if (!ext_fault) begin
            if (low_q == CW'(MIN_CYC - 1)) begin
                ext_fault <= 1'b1;
            end else begin
                low_q <= low_q + 1'b1;
            end
        end
    end

    // R6: a released request drops the latched shutdown on the next cycle
    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        prot_s |=> !ext_fault);

    // R5: the shutdown is only accepted while the request is held low
    a_r5_accept_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_fault) |-> !$past(prot_s));

endmodule

// File: rtl/gate_fault_ctrl.sv
module gate_fault_ctrl
    import gfc_pkg::*;
#(
    parameter int NCH          = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int PROT_MIN_CYC = 100,
    parameter int CLK_LOSS_CYC = 1024
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pwm_i,
    input  logic           uv_i,
    input  logic           ot_i,
    input  logic           prot_n_i,
    input  logic [NCH-1:0] dt_hs_i,
    input  logic [NCH-1:0] dt_ls_i,
    output logic [NCH-1:0] gate_hs_o,
    output logic [NCH-1:0] gate_ls_o,
    output logic           fault_n_o
);

    localparam int             SW       = NCH + 3;
    localparam logic [SW-1:0]  SYNC_RST = {1'b1, {(NCH + 2){1'b0}}};

    logic [SW-1:0]  sync_q;
    logic [NCH-1:0] pwm_s;
    logic           uv_s;
    logic           ot_s;
    logic           prot_s;
    logic           pwm_rise;
    logic           clk_lost;
    logic           ext_fault;
    gfc_fault_t     flt;
    gfc_state_e     state_q;
    gfc_state_e     state_d;

    // all pin-level inputs share one synchronizer bank
    gfc_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({prot_n_i, ot_i, uv_i, pwm_i}),
        .q     (sync_q)
    );

    assign {prot_s, ot_s, uv_s, pwm_s} = sync_q;

    gfc_edge_watch #(
        .NPWM     (NCH),
        .LOSS_CYC (CLK_LOSS_CYC)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_s    (pwm_s),
        .rise_any (pwm_rise),
        .lost_o   (clk_lost)
    );

    gfc_ext_qual #(
        .MIN_CYC (PROT_MIN_CYC)
    ) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_s    (prot_s),
        .ext_fault (ext_fault)
    );

    always_comb begin
        flt.uv       = uv_s;
        flt.ot       = ot_s;
        flt.clk_lost = clk_lost;
        flt.ext      = ext_fault;
    end

    // next-state: uv_trip, fault_trip, resume, hold
    always_comb begin
        state_d = state_q;
        if (flt.uv) begin
            state_d = ST_CHARGE;
        end else if (flt.ot || flt.clk_lost || flt.ext) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_CHARGE, ST_OFF: if (pwm_rise) state_d = ST_RUN;
                ST_RUN:            state_d = ST_RUN;
                default:           state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CHARGE;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_RUN: begin
                gate_hs_o = dt_hs_i;
                gate_ls_o = dt_ls_i;
                fault_n_o = 1'b1;
            end
            ST_CHARGE: begin
                gate_hs_o = '0;
                gate_ls_o = '1;
                fault_n_o = 1'b0;
            end
            default: begin
                gate_hs_o = '0;
                gate_ls_o = '0;
                fault_n_o = 1'b0;
            end
        endcase
    end

    // R3: synchronized undervoltage gives the bootstrap-charge pattern next cycle
    a_r3_uv_forces_charge: assert property (@(posedge clk) disable iff (!rst_n)
        flt.uv |=> (gate_hs_o == '0 && gate_ls_o == '1 && !fault_n_o));

    // R4: any other fault without undervoltage turns every gate off
    a_r4_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt.uv && (flt.ot || flt.clk_lost || flt.ext))
        |=> (gate_hs_o == '0 && gate_ls_o == '0 && !fault_n_o));

    // R8: the flag is released only after a PWM rising edge was seen
    a_r8_resume_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n_o) |-> $past(pwm_rise));

    // R9: while any fault remains the flag stays asserted
    a_r9_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n_o && (|flt)) |=> !fault_n_o);

endmodule

// File: tb/gate_fault_ctrl_bench.sv
module gate_fault_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int PMIN       = 4;
    localparam int LOSS       = 64;
    localparam int HOLD       = 8;
    localparam int NVEC       = 19;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pwm = '0;
    logic           uv = 1'b0;
    logic           ot = 1'b0;
    logic           pn = 1'b1;
    logic [NCH-1:0] dths = 2'b01;
    logic [NCH-1:0] dtls = 2'b10;
    logic [NCH-1:0] gate_hs;
    logic [NCH-1:0] gate_ls;
    logic           fault_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gate_fault_ctrl #(
        .NCH          (NCH),
        .SYNC_STAGES  (2),
        .PROT_MIN_CYC (PMIN),
        .CLK_LOSS_CYC (LOSS)
    ) u_gate_fault_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_i     (pwm),
        .uv_i      (uv),
        .ot_i      (ot),
        .prot_n_i  (pn),
        .dt_hs_i   (dths),
        .dt_ls_i   (dtls),
        .gate_hs_o (gate_hs),
        .gate_ls_o (gate_ls),
        .fault_n_o (fault_n)
    );

    // fields: uv, ot, prot_n, pwm{b,a}, dt_hs, dt_ls, expected (0 CHARGE, 1 OFF, 2 RUN)
    localparam logic [10:0] VEC [NVEC] = '{
        11'b0_0_1_00_01_10_00, // 0  after reset, no edge: R1
        11'b0_0_1_01_01_10_10, // 1  rise on side A: R1 resume
        11'b0_0_1_00_10_01_10, // 2  run with other commands: R2
        11'b1_0_1_00_10_01_00, // 3  undervoltage: R3
        11'b1_0_1_01_10_01_00, // 4  rise during fault ignored: R8
        11'b0_0_1_00_10_01_00, // 5  cleared, no rise yet: R8
        11'b0_0_1_10_11_00_10, // 6  rise on side B: R8
        11'b0_1_1_10_01_10_01, // 7  over-temperature: R4
        11'b0_0_1_00_01_10_01, // 8  cleared, only a fall: R8
        11'b0_0_1_01_00_11_10, // 9  rise resumes: R8
        11'b1_1_1_00_01_10_00, // 10 both faults, charge wins: R9
        11'b0_1_1_00_01_10_01, // 11 temperature still high: R9
        11'b0_0_1_00_01_10_01, // 12 flag still low: R9
        11'b0_0_1_10_10_01_10, // 13 rise resumes: R9
        11'b0_0_0_10_10_01_01, // 14 shutdown held long: R5
        11'b1_0_0_10_10_01_00, // 15 undervoltage over shutdown: R9
        11'b0_0_0_11_10_01_01, // 16 rise while still low: R6
        11'b0_0_1_00_10_01_01, // 17 released, no rise: R6
        11'b0_0_1_01_01_10_10  // 18 rise resumes: R6
    };

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [NCH-1:0] ehs,
                       input logic [NCH-1:0] els, input logic ef);
        checks++;
        if ({gate_hs, gate_ls, fault_n} !== {ehs, els, ef}) begin
            fails++;
            $display("FAIL %s: actual hs=%b ls=%b flag=%b expected hs=%b ls=%b flag=%b",
                     tag, gate_hs, gate_ls, fault_n, ehs, els, ef);
        end
    endtask

    task automatic chk_state(input string tag, input int code);
        case (code)
            0:       chk(tag, 2'b00, 2'b11, 1'b0);
            1:       chk(tag, 2'b00, 2'b00, 1'b0);
            default: chk(tag, dths, dtls, 1'b1);
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion of all requirement checks");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        waitn(2);
        chk("R1 during reset", 2'b00, 2'b11, 1'b0);
        rst_n = 1'b1;
        waitn(HOLD);
        chk("R1 after release", 2'b00, 2'b11, 1'b0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            {uv, ot, pn, pwm, dths, dtls} = VEC[i][10:2];
            waitn(HOLD);
            chk_state($sformatf("R2/R3/R4 vector %0d", i), int'(VEC[i][1:0]));
        end

        // R5: a pulse one cycle too short is ignored
        begin
            logic ok;
            ok = 1'b1;
            pn = 1'b0;
            waitn(PMIN - 1);
            pn = 1'b1;
            repeat (12) begin
                @(negedge clk);
                if (!fault_n || gate_hs !== dths) ok = 1'b0;
            end
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL R5 short pulse: actual=forced expected=RUN unchanged");
            end
        end

        // R5 / R6: minimum-width pulse accepted, recovery at a later rise
        pn = 1'b0;
        waitn(PMIN);
        pn = 1'b1;
        waitn(HOLD - PMIN);
        chk("R5 min pulse accepted", 2'b00, 2'b00, 1'b0);
        pwm = 2'b00;
        waitn(4);
        chk("R6 fall does not resume", 2'b00, 2'b00, 1'b0);
        pwm = 2'b01;
        waitn(4);
        chk("R6 rise resumes", dths, dtls, 1'b1);

        // R7: clock loss timing
        pwm = 2'b00;
        waitn(LOSS + 3);
        chk("R7 still running before limit", dths, dtls, 1'b1);
        waitn(1);
        chk("R7 loss forces off", 2'b00, 2'b00, 1'b0);

        // R10: clearing edge does not resume, the next rise does
        pwm = 2'b10;
        waitn(4);
        chk("R10 clearing rise no resume", 2'b00, 2'b00, 1'b0);
        pwm = 2'b00;
        waitn(4);
        chk("R10 after fall still off", 2'b00, 2'b00, 1'b0);
        pwm = 2'b10;
        waitn(4);
        chk("R10 next rise resumes", dths, dtls, 1'b1);

        // R1: reset during operation
        pwm = 2'b00;
        waitn(4);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", 2'b00, 2'b11, 1'b0);
        waitn(1);
        rst_n = 1'b1;
        waitn(HOLD);
        chk("R1 hold charge after reset", 2'b00, 2'b11, 1'b0);
        pwm = 2'b01;
        waitn(4);
        chk("R1 resume after reset", dths, dtls, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule